// File: doc/BRIEF.md
# Serial Character Sender with Even Parity

This block accepts a parallel word made of a seven-bit character and an empty top bit. It sends the word out on one serial wire, one bit per clock cycle. The character bits leave lowest bit first. As each bit goes out, a single state flip-flop folds it into a running parity value. In the eighth and last slot, the block sends that computed parity instead of the empty top bit, so the serial word always carries a correct parity bit.

A short load strobe with the word starts a transfer. The busy output marks the eight cycles in which the serial wire carries data. A one-cycle done pulse follows the last slot. The block frames nothing else: it adds no start bit and no stop bit. The parity sense is a parameter, even by default. The character width is also a parameter.

Top module: `p2s_parity_tx`

## Requirements
- R1: After reset, busy_o, done_o and ser_o are all 0.
- R2: A load_i pulse seen at a clock edge while idle starts a transfer. busy_o is then 1 for exactly 8 consecutive cycles, beginning in the cycle after that edge.
- R3: In busy slots 0 through 6, ser_o carries word_i bits 0 through 6 of the loaded word, in that order (lowest bit first).
- R4: In busy slot 7, ser_o carries the parity bit. With the default even sense, the eight transmitted bits together contain an even number of ones. The value on word_i bit 7 at load time has no effect on any slot.
- R5: done_o is 1 for exactly one cycle, the cycle right after slot 7, and busy_o is 0 in that cycle.
- R6: A load_i raised while busy_o is 1 is ignored. The running transfer keeps its bit sequence and its length.
- R7: The parity state clears at every accepted load. A word loaded in the done cycle, back to back with the previous word, gets a parity that depends only on its own bits.
- R8: ser_o is 0 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start strobe, taken only while idle |
| word_i | input | 8 | Character in bits 6..0, empty parity slot in bit 7 |
| ser_o | output | 1 | Serial data, one bit per cycle |
| busy_o | output | 1 | High during the eight data slots |
| done_o | output | 1 | One-cycle pulse after the last slot |

## Verification
A parity flip-flop that fails to clear, or that misses a bit, changes only slot 7 of that word. So every slot-7 value is compared against parity computed from the driven word. Back-to-back words with odd character parity expose a stale parity state within one word. A wrong slot counter shows at once: busy_o runs too long or too short, or done_o lands in the wrong cycle. A wrong shift order makes the very first data slot differ from word bit 0. An ignored-load fault is exposed by raising load_i mid-word with the inverted word: any capture corrupts the remaining slots within one cycle.

// File: rtl/p2s_pkg.sv
package p2s_pkg;

   typedef enum logic [0:0] {
      P2S_IDLE = 1'b0,
      P2S_SEND = 1'b1
   } p2s_state_e;

   function automatic int p2s_cnt_width(input int slots);
      return (slots <= 2) ? 1 : $clog2(slots);
   endfunction

endpackage

// File: rtl/p2s_shift_reg.sv
module p2s_shift_reg #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              shift_en,
   input  logic [WORD_W-1:0] data_i,
   output logic              bit_o
);

   logic [WORD_W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load_en) begin
         q <= data_i;
      end else if (shift_en) begin
         q <= {1'b0, q[WORD_W-1:1]};
      end
   end

   assign bit_o = q[0];

endmodule

// File: rtl/p2s_slot_ctr.sv
module p2s_slot_ctr #(
   parameter int WORD_W = 8,
   parameter int CNT_W  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic adv,
   output logic last_o
);

   localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (adv) begin
         cnt <= (cnt == LAST_SLOT) ? '0 : cnt + 1'b1;
      end
   end

   assign last_o = (cnt == LAST_SLOT);

endmodule

// File: rtl/p2s_parity_ff.sv
module p2s_parity_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic en,
   input  logic bit_i,
   output logic par_o
);

   logic par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b0;
      end else if (clear) begin
         par_q <= 1'b0;
      end else if (en) begin
         par_q <= par_q ^ bit_i;
      end
   end

   assign par_o = par_q;

endmodule

// File: rtl/p2s_ctrl.sv
module p2s_ctrl
   import p2s_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic last_i,
   output logic start_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);

   p2s_state_e state_q, state_d;
   logic       done_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         P2S_IDLE: if (load_i) state_d = P2S_SEND;
         P2S_SEND: if (last_i) state_d = P2S_IDLE;
         default:  state_d = P2S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= P2S_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == P2S_SEND) && last_i;
      end
   end

   assign start_o = (state_q == P2S_IDLE) && load_i;
   assign step_o  = (state_q == P2S_SEND);
   assign busy_o  = (state_q == P2S_SEND);
   assign done_o  = done_q;

endmodule

// File: rtl/p2s_parity_tx.sv
module p2s_parity_tx
   import p2s_pkg::*;
#(
   parameter int DATA_W     = 7,
   parameter int PARITY_ODD = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [DATA_W:0]     word_i,
   output logic                ser_o,
   output logic                busy_o,
   output logic                done_o
);

   localparam int WORD_W = DATA_W + 1;
   localparam int CNT_W  = p2s_cnt_width(WORD_W);

   if (DATA_W < 1) begin : g_bad_width
      $error("p2s_parity_tx: DATA_W must be at least 1");
   end
   if (PARITY_ODD != 0 && PARITY_ODD != 1) begin : g_bad_sense
      $error("p2s_parity_tx: PARITY_ODD must be 0 or 1");
   end

   logic start, step, last, sh_bit, par_q, par_bit, busy;

   p2s_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .last_i  (last),
      .start_o (start),
      .step_o  (step),
      .busy_o  (busy),
      .done_o  (done_o)
   );

   p2s_shift_reg #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (start),
      .shift_en (step),
      .data_i   (word_i),
      .bit_o    (sh_bit)
   );

   p2s_slot_ctr #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start),
      .adv    (step),
      .last_o (last)
   );

   p2s_parity_ff u_par (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .en    (step && !last),
      .bit_i (sh_bit),
      .par_o (par_q)
   );

   if (PARITY_ODD == 1) begin : g_odd
      assign par_bit = ~par_q;
   end else begin : g_even
      assign par_bit = par_q;
   end

   assign ser_o  = busy & (last ? par_bit : sh_bit);
   assign busy_o = busy;

endmodule

// File: rtl/p2s_parity_tx_chk.sv
module p2s_parity_tx_chk #(
   parameter int WORD_W     = 8,
   parameter int PARITY_ODD = 0
) (
   input logic clk,
   input logic rst_n,
   input logic load,
   input logic busy,
   input logic done,
   input logic ser
);

   localparam int BW = $clog2(WORD_W + 1);
   localparam logic [BW-1:0] LASTC = BW'(WORD_W - 1);
   localparam logic [BW-1:0] LIMIT = BW'(WORD_W);
   localparam logic SENSE = (PARITY_ODD == 1);

   logic [BW-1:0] bcnt;
   logic          acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt <= '0;
         acc  <= 1'b0;
      end else if (busy) begin
         bcnt <= bcnt + 1'b1;
         acc  <= acc ^ ser;
      end else begin
         bcnt <= '0;
         acc  <= 1'b0;
      end
   end

   assert_busy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bcnt < LIMIT));

   assert_busy_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(bcnt) == LASTC));

   assert_start_from_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(load));

   assert_parity_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bcnt == LASTC) |-> (ser == (acc ^ SENSE)));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_idle_line_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ser);

endmodule

bind p2s_parity_tx p2s_parity_tx_chk #(
   .WORD_W     (WORD_W),
   .PARITY_ODD (PARITY_ODD)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .load  (load_i),
   .busy  (busy_o),
   .done  (done_o),
   .ser   (ser_o)
);

// File: tb/sim_p2s_parity_tx.sv
`timescale 1ns/1ps
module sim_p2s_parity_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_i = 1'b0;
   logic [7:0] word_i = '0;
   logic       ser_o, busy_o, done_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit ended = 0;

   always #2 clk = ~clk;

   p2s_parity_tx u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .word_i (word_i),
      .ser_o  (ser_o),
      .busy_o (busy_o),
      .done_o (done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Sends one word; optionally injects a stray load at slot inj,
   // and optionally queues the next word during the done cycle.
   task automatic run_word(input logic [7:0] w, input int inj, input bit pre,
                           input bit chain, input logic [7:0] nxt);
      logic exp_bit;
      if (!pre) begin
         @(negedge clk);
         load_i = 1'b1;
         word_i = w;
      end
      @(negedge clk);
      load_i = 1'b0;
      word_i = 8'h00;
      for (int k = 0; k < 8; k++) begin
         exp_bit = (k < 7) ? w[k] : ^w[6:0];
         if (k < 7) chk(ser_o == exp_bit, "R3 data slot", ser_o, exp_bit);
         else       chk(ser_o == exp_bit, "R4 parity slot", ser_o, exp_bit);
         chk(busy_o == 1'b1, "R2 busy in slot", busy_o, 1);
         chk(done_o == 1'b0, "R5 no done in slot", done_o, 0);
         if (k == inj) begin
            load_i = 1'b1;
            word_i = ~w;
         end else if (k == inj + 1) begin
            load_i = 1'b0;
            word_i = 8'h00;
         end
         @(negedge clk);
      end
      chk(busy_o == 1'b0, "R5 busy low at done", busy_o, 0);
      chk(done_o == 1'b1, "R5 done pulse", done_o, 1);
      chk(ser_o == 1'b0, "R8 idle line", ser_o, 0);
      if (chain) begin
         load_i = 1'b1;
         word_i = nxt;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      #9;
      chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
      chk(done_o == 1'b0, "R1 done", done_o, 0);
      chk(ser_o == 1'b0, "R1 ser", ser_o, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_basic_words();
      run_word(8'h41, -9, 0, 0, 8'h00);
      run_word(8'h43, -9, 0, 0, 8'h00);
      run_word(8'h00, -9, 0, 0, 8'h00);
      run_word(8'h7F, -9, 0, 0, 8'h00);
      @(negedge clk);
      chk(done_o == 1'b0, "R5 done one cycle", done_o, 0);
      chk(ser_o == 1'b0, "R8 idle line", ser_o, 0);
   endtask

   task automatic t_placeholder_set();
      // R4: bit 7 of the loaded word set to 1 must not reach the line
      run_word(8'hC1, -9, 0, 0, 8'h00);
      run_word(8'h80, -9, 0, 0, 8'h00);
   endtask

   task automatic t_load_while_busy();
      // R6: stray load mid-word with inverted data
      run_word(8'h35, 2, 0, 0, 8'h00);
      run_word(8'h6A, 6, 0, 0, 8'h00);
   endtask

   task automatic t_back_to_back();
      // R7: odd-parity word followed at once by another word
      run_word(8'h01, -9, 0, 1, 8'h06);
      run_word(8'h06, -9, 1, 1, 8'h07);
      run_word(8'h07, -9, 1, 0, 8'h00);
      @(negedge clk);
      chk(busy_o == 1'b0, "R2 stays idle", busy_o, 0);
   endtask

   task automatic t_idle_quiet();
      // R8: line stays low for many idle cycles
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(ser_o == 1'b0 && busy_o == 1'b0, "R8 idle", ser_o, 0);
      end
   endtask

   initial begin
      t_reset();
      t_basic_words();
      t_placeholder_set();
      t_load_while_busy();
      t_back_to_back();
      t_idle_quiet();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!ended) begin
         ended = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule